// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a core whose calling convention rotates a register window on every call and return. Software always names 32 registers with a 5-bit index. Eight of them are globals that every window shares. The other 24 are translated through a current-window pointer onto a larger physical array. The array has `NWIN` windows. Each window owns sixteen registers: eight locals and eight outs. The eight ins of a window are not stored on their own: they are the outs of the window just below it in the ring. A call therefore passes arguments without copying any data.

The block has two combinational read ports and one write port, which is clocked. A `save_i` strobe moves the pointer up one window and a `restore_i` strobe moves it back. A small control machine counts how many windows are live. When a rotation would run out of windows, the machine refuses the move and, on the following cycle, raises a one-cycle overflow or underflow trap. Spilling to memory is left to whatever handles the trap. The control machine has three named states. RUN means no trap is flagged. OVF is entered on a refused save. UNF is entered on a refused restore. Every transition is re-decided each cycle: a refused save goes to OVF, a refused restore goes to UNF, and any other input returns the machine to RUN.

`NWIN` must be a power of two. At most `NWIN-1` windows can be live at once. This keeps the current window's outs apart from the ins of the oldest live window.

Top module: `winreg_file`

## Requirements
- R1: Index bits [4:3] select the group: 0 = globals (r0–r7), 1 = outs (r8–r15), 2 = locals (r16–r23), 3 = ins (r24–r31). Globals r1–r7 hold their values whatever the current window is.
- R2: Reading r0 on either port returns zero. A write to r0 has no effect.
- R3: After an accepted save, the new window's ins (r24+k) read the values the previous window held in its outs (r8+k).
- R4: Each window's locals are private. Values written to locals in a deeper window do not change the locals of a shallower window.
- R5: An accepted restore returns to the caller's window. The caller's outs (r8+k) then read the values the callee wrote to its ins (r24+k).
- R6: A save while `NWIN-1` windows are live does not move the window. In the next cycle `trap_overflow` is 1 for one cycle.
- R7: A restore while only one window is live does not move the window. In the next cycle `trap_underflow` is 1 for one cycle.
- R8: Reads are combinational. A read of the register being written in the same cycle returns the old value. The new value is visible after the rising edge.
- R9: Synchronous reset selects window 0 with one live window and clears both trap outputs.
- R10: When `save_i` and `restore_i` are high in the same cycle, the save is acted on and the restore is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Read port A architectural index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 5 | Read port B architectural index |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural index |
| wr_data | input | DW | Write data |
| save_i | input | 1 | Rotate to a new window |
| restore_i | input | 1 | Rotate back to the caller window |
| trap_overflow | output | 1 | Refused save, one-cycle pulse |
| trap_underflow | output | 1 | Refused restore, one-cycle pulse |

## Verification
Window 0 is filled through all 31 writable indices, and each index is read back on both ports. Data that depends on the window number is then carried down through every save up to the overflow point. At each depth the ins, locals and globals are compared with values the bench computes from the window number and the register index. This separates a correct in/out alias from an off-by-one window base, and separates private locals from shared ones. The climb back up writes a different pattern into the ins, so each restore shows whether the callee's results reach the caller's outs. Both refusal boundaries are driven, and so is a simultaneous save and restore. Separate stimuli cover the r0 write and the read-during-write case.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_OVF = 2'd1,
        ST_UNF = 2'd2
    } wctl_state_e;

    localparam logic [1:0] GRP_GLB = 2'd0;
    localparam logic [1:0] GRP_OUT = 2'd1;
    localparam logic [1:0] GRP_LOC = 2'd2;
    localparam logic [1:0] GRP_IN  = 2'd3;
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int PW = CW + 4
) (
    input  logic [CW-1:0] cwp,
    input  logic [4:0]    arch,
    output logic          is_glb,
    output logic [2:0]    glb_idx,
    output logic [PW-1:0] win_idx
);
    logic [CW-1:0] base;
    logic          upper;

    always_comb begin
        is_glb  = 1'b0;
        base    = cwp;
        upper   = 1'b0;
        glb_idx = arch[2:0];
        unique case (arch[4:3])
            GRP_GLB: is_glb = 1'b1;
            GRP_OUT: upper = 1'b1;
            GRP_LOC: upper = 1'b0;
            GRP_IN: begin
                // ins live in the out half of the window below (R3)
                base  = cwp - CW'(1);
                upper = 1'b1;
            end
            default: is_glb = 1'b1;
        endcase
        win_idx = {base, upper, arch[2:0]};
    end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int NW = $clog2(NWIN) + 1,
    localparam logic [NW-1:0] MAXV = NW'(NWIN - 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          save_i,
    input  logic          restore_i,
    output logic [CW-1:0] cwp,
    output logic          trap_ovf,
    output logic          trap_unf
);
    wctl_state_e   st_q, st_d;
    logic [CW-1:0] cwp_q, cwp_d;
    logic [NW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            cwp_q <= '0;
            cnt_q <= NW'(1);
        end else begin
            st_q  <= st_d;
            cwp_q <= cwp_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: save wins over restore (R10)
    always_comb begin
        st_d  = ST_RUN;
        cwp_d = cwp_q;
        cnt_d = cnt_q;
        if (save_i) begin
            if (cnt_q == MAXV) begin
                st_d = ST_OVF;
            end else begin
                cwp_d = cwp_q + CW'(1);
                cnt_d = cnt_q + NW'(1);
            end
        end else if (restore_i) begin
            if (cnt_q == NW'(1)) begin
                st_d = ST_UNF;
            end else begin
                cwp_d = cwp_q - CW'(1);
                cnt_d = cnt_q - NW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        trap_ovf = 1'b0;
        trap_unf = 1'b0;
        unique case (st_q)
            ST_RUN: ;
            ST_OVF: trap_ovf = 1'b1;
            ST_UNF: trap_unf = 1'b1;
            default: ;
        endcase
    end

    assign cwp = cwp_q;

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (save_i && cnt_q == MAXV) |=> (trap_ovf && cwp_q == $past(cwp_q)));

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (restore_i && !save_i && cnt_q == NW'(1)) |=> (trap_unf && cwp_q == $past(cwp_q)));

    p_save_step_r3: assert property (@(posedge clk) disable iff (rst)
        (save_i && cnt_q != MAXV) |=> (cwp_q == $past(cwp_q) + CW'(1)));

    p_live_range_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= NW'(1) && cnt_q <= MAXV));

    p_trap_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(trap_ovf && trap_unf));
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int DW   = 32,
    parameter int NWIN = 8,
    localparam int PW    = $clog2(NWIN) + 4,
    localparam int DEPTH = NWIN * 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic          w_glb,
    input  logic [2:0]    w_gidx,
    input  logic [PW-1:0] w_widx,
    input  logic [DW-1:0] wdata,
    input  logic          a_glb,
    input  logic [2:0]    a_gidx,
    input  logic [PW-1:0] a_widx,
    output logic [DW-1:0] a_data,
    input  logic          b_glb,
    input  logic [2:0]    b_gidx,
    input  logic [PW-1:0] b_widx,
    output logic [DW-1:0] b_data
);
    logic [DW-1:0] gbank [8];
    logic [DW-1:0] wbank [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            if (w_glb) begin
                if (w_gidx != 3'd0) gbank[w_gidx] <= wdata;  // R2
            end else begin
                wbank[w_widx] <= wdata;
            end
        end
    end

    always_comb begin
        if (a_glb) a_data = (a_gidx == 3'd0) ? '0 : gbank[a_gidx];
        else       a_data = wbank[a_widx];
        if (b_glb) b_data = (b_gidx == 3'd0) ? '0 : gbank[b_gidx];
        else       b_data = wbank[b_widx];
    end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int DW   = 32,
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int PW = CW + 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [4:0]    rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [4:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          save_i,
    input  logic          restore_i,
    output logic          trap_overflow,
    output logic          trap_underflow
);
    logic [CW-1:0]      cwp;
    logic [2:0][4:0]    arch;
    logic [2:0]         is_glb;
    logic [2:0][2:0]    gidx;
    logic [2:0][PW-1:0] widx;

    assign arch = {wr_idx, rd_b_idx, rd_a_idx};

    wrf_window_ctl #(.NWIN(NWIN)) ctl_i (
        .clk(clk), .rst(rst), .save_i(save_i), .restore_i(restore_i),
        .cwp(cwp), .trap_ovf(trap_overflow), .trap_unf(trap_underflow)
    );

    for (genvar p = 0; p < 3; p++) begin : g_map
        wrf_addr_map #(.NWIN(NWIN)) map_i (
            .cwp(cwp), .arch(arch[p]), .is_glb(is_glb[p]),
            .glb_idx(gidx[p]), .win_idx(widx[p])
        );
    end

    wrf_storage #(.DW(DW), .NWIN(NWIN)) store_i (
        .clk(clk), .we(wr_en),
        .w_glb(is_glb[2]), .w_gidx(gidx[2]), .w_widx(widx[2]), .wdata(wr_data),
        .a_glb(is_glb[0]), .a_gidx(gidx[0]), .a_widx(widx[0]), .a_data(rd_a_data),
        .b_glb(is_glb[1]), .b_gidx(gidx[1]), .b_widx(widx[1]), .b_data(rd_b_data)
    );

    p_zero_read_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    p_zero_read_b_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
endmodule

// File: tb/winreg_file_tb_top.sv
module winreg_file_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NWIN = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [4:0]    rd_a_idx, rd_b_idx, wr_idx;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
    logic          wr_en, save_i, restore_i;
    logic          trap_overflow, trap_underflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    winreg_file #(.DW(DW), .NWIN(NWIN)) dut_i (.*);

    function automatic logic [DW-1:0] wv(int w, int i);
        return 32'hA000_0000 + DW'(w * 256 + i);
    endfunction

    function automatic logic [DW-1:0] gv(int i);
        return 32'hC000_0000 + DW'(i);
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int idx, logic [DW-1:0] val);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_data = val;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(string tag, int idx, logic [DW-1:0] exp);
        rd_a_idx = 5'(idx); rd_b_idx = 5'(idx);
        #1;
        check({tag, " portA"}, rd_a_data, exp);
        check({tag, " portB"}, rd_b_data, exp);
    endtask

    task automatic rotate(bit s, bit r);
        save_i = s; restore_i = r;
        tick();
        save_i = 1'b0; restore_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; save_i = 0; restore_i = 0;
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        repeat (3) tick();
        rst = 1'b0;
        // R9 reset state
        check("R9 ovf clear", DW'(trap_overflow), 0);
        check("R9 unf clear", DW'(trap_underflow), 0);
        rd("R2 r0 at reset", 0, 0);

        // R2 write to r0 discarded
        wr(0, 32'hFFFF_FFFF);
        rd("R2 r0 after write", 0, 0);

        // R8 read during write returns old value
        wr(5, 32'h1111_1111);
        wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'h2222_2222;
        rd_a_idx = 5'd5; #1;
        check("R8 old value same cycle", rd_a_data, 32'h1111_1111);
        tick(); wr_en = 1'b0;
        rd("R8 new value after edge", 5, 32'h2222_2222);

        // fill window 0 (R1 group layout)
        for (int i = 1; i < 8; i++) wr(i, gv(i));
        for (int i = 8; i < 32; i++) wr(i, wv(0, i));
        for (int i = 1; i < 8; i++) rd("R1 global w0", i, gv(i));
        for (int i = 8; i < 32; i++) rd("R1 window0 readback", i, wv(0, i));

        // climb: saves to depth 6 (7 live windows)
        for (int d = 1; d < NWIN - 1; d++) begin
            rotate(1, 0);
            check("R6 no trap on accepted save", DW'(trap_overflow), 0);
            for (int k = 0; k < 8; k++) rd("R3 ins alias caller outs", 24 + k, wv(d - 1, 8 + k));
            for (int i = 1; i < 8; i++) rd("R1 globals shared", i, gv(i));
            for (int i = 8; i < 24; i++) wr(i, wv(d, i));
        end

        // overflow at 7 live windows
        rotate(1, 0);
        check("R6 overflow trap", DW'(trap_overflow), 1);
        check("R6 no underflow", DW'(trap_underflow), 0);
        for (int k = 0; k < 8; k++) rd("R6 window unmoved ins", 24 + k, wv(NWIN - 3, 8 + k));
        for (int k = 0; k < 8; k++) rd("R6 window unmoved locals", 16 + k, wv(NWIN - 2, 16 + k));
        tick();
        check("R6 trap one cycle", DW'(trap_overflow), 0);

        // R10 both strobes: save wins
        rotate(1, 1);
        check("R10 save wins ovf", DW'(trap_overflow), 1);
        check("R10 restore ignored unf", DW'(trap_underflow), 0);
        rd("R10 window unmoved", 16, wv(NWIN - 2, 16));
        tick();

        // descend: callee writes ins, caller sees them in outs
        for (int d = NWIN - 2; d > 0; d--) begin
            for (int k = 0; k < 8; k++) wr(24 + k, wv(20 + d, k));
            rotate(0, 1);
            check("R7 no trap on accepted restore", DW'(trap_underflow), 0);
            for (int k = 0; k < 8; k++) rd("R5 caller outs get results", 8 + k, wv(20 + d, k));
            for (int k = 0; k < 8; k++) rd("R4 locals private", 16 + k, wv(d - 1, 16 + k));
        end

        // underflow at one live window
        rotate(0, 1);
        check("R7 underflow trap", DW'(trap_underflow), 1);
        check("R7 no overflow", DW'(trap_overflow), 0);
        for (int k = 0; k < 8; k++) rd("R7 window unmoved locals", 16 + k, wv(0, 16 + k));
        tick();
        check("R7 trap one cycle", DW'(trap_underflow), 0);

        // R9 reset again returns to base window
        rotate(1, 0);
        rst = 1'b1; tick(); rst = 1'b0;
        check("R9 traps clear after reset", DW'(trap_overflow | trap_underflow), 0);
        for (int k = 0; k < 8; k++) rd("R9 window 0 after reset", 16 + k, wv(0, 16 + k));
        rotate(0, 1);
        check("R9 one live window", DW'(trap_underflow), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule